// File: doc/BRIEF.md
# Coprocessor Compare Unit with Condition Flags

This block takes a 32-bit coprocessor instruction word, recognises two compare operations in it, and compares two operands that it fetches from a sixteen-entry, 64-bit coprocessor register file through two combinational read ports. One operation compares the operands as IEEE-754 double-precision numbers. The other compares the low 32 bits of each entry as signed integers. Both operations produce a four-bit set of condition flags: negative, zero, carry and overflow.

The flags leave the block by one of two routes. Normally they form the top nibble of a 32-bit word, and that word is written to the host register named by the instruction's destination field. When that field names register 15, no host register is written. A separate strobe instead loads the four flags straight into the host status register. An instruction word that fits neither compare encoding writes nothing and raises a one-cycle unrecognised-instruction pulse. Each instruction gets exactly one registered outcome, one clock after it is presented.

Top module: `cmp_flag_unit`

## Requirements
- R1: A word is recognised only when bits 27:24 are 1110, bits 23:22 are 00, bit 21 is 0, bit 20 is 1 and bit 4 is 1, and its operation field matches one of the two compares. Any other valid word asserts `undef_instr` for one cycle and asserts neither `reg_we` nor `flag_we`.
- R2: `rd_addr_a` carries instruction bits 19:16 and `rd_addr_b` carries bits 3:0. The destination register number is bits 15:12.
- R3: Bits 11:8 = 0100 with bits 7:5 = 101 select the double compare. Bits 11:8 = 0101 with bits 7:5 = 100 select the integer compare.
- R4: The written word holds the flags N, Z, C, V in bits 31, 30, 29 and 28, and bits 27:0 are zero.
- R5: When the destination is 15, `flag_we` pulses and `flag_nzcv` carries {N,Z,C,V} (N in bit 3), and `reg_we` stays low.
- R6: For the integer compare the flags come from first minus second: Z is set on equality, N is bit 31 of the difference, C is set when no borrow occurs (first >= second unsigned), and V is set on signed overflow.
- R7: For the double compare, equal gives NZCV=0110, less-than gives 1000 and greater-than gives 0010. Ordering follows the real values, including negative operands and infinities.
- R8: If either double operand is a NaN (exponent all ones, nonzero fraction), the result is unordered, NZCV=0011.
- R9: Positive zero and negative zero compare as equal.
- R10: The outcome (`reg_we`, `flag_we` or `undef_instr`) is a single-cycle pulse in the cycle after `instr_valid`. At most one of `reg_we` and `flag_we` is high, and all three are low when no instruction was presented.
- R11: Instruction bits 31:28 do not affect decoding or the result.
- R12: The integer compare uses only bits 31:0 of each register entry. Bits 63:32 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Coprocessor instruction word |
| rd_addr_a | output | 4 | First operand read address |
| rd_data_a | input | 64 | First operand read data (same cycle) |
| rd_addr_b | output | 4 | Second operand read address |
| rd_data_b | input | 64 | Second operand read data (same cycle) |
| reg_we | output | 1 | Host register write strobe |
| reg_waddr | output | 4 | Host register number to write |
| reg_wdata | output | 32 | Host register word, flags in the top nibble |
| flag_we | output | 1 | Host status flag write strobe |
| flag_nzcv | output | 4 | Flags for the status register, N in bit 3 |
| undef_instr | output | 1 | Unrecognised instruction pulse |

## Verification
The read addresses are combinational from the instruction word, so the bench checks them in the same cycle as the word, before the rising edge. Every other result is registered once: `reg_we`, `flag_we`, `undef_instr` and their data belong to the cycle after the one in which `instr_valid` was high. The bench drives each instruction on a falling edge and drops `instr_valid` on the next falling edge. It samples the outcome at that falling edge, which is the only cycle in which the outcome exists. One falling edge later it checks that all three strobes have dropped again.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int INSTR_W   = 32;
    localparam int REG_AW    = 4;
    localparam int FLAG_W    = 4;
    localparam int RES_W     = 32;
    localparam logic [REG_AW-1:0] FLAG_DEST = 4'd15;

    // operation field values: {bits 11:8, bits 7:5}
    localparam logic [6:0] OPF_DBL = 7'b0100_101;
    localparam logic [6:0] OPF_INT = 7'b0101_100;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_DBL  = 2'd1,
        OPK_INT  = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2,
        ORD_UN = 2'd3
    } order_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        op_kind_e            kind;
        logic [REG_AW-1:0]   src_a;
        logic [REG_AW-1:0]   src_b;
        logic [REG_AW-1:0]   dest;
    } decoded_t;

    // fixed bits shared by both compare encodings
    function automatic logic frame_ok(input logic [INSTR_W-1:0] w);
        return (w[27:24] == 4'b1110) && (w[23:22] == 2'b00) &&
               !w[21] && w[20] && w[4];
    endfunction

    function automatic nzcv_t order_flags(input order_e o);
        nzcv_t f;
        case (o)
            ORD_LT:  f = '{n: 1'b1, z: 1'b0, c: 1'b0, v: 1'b0};
            ORD_EQ:  f = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};
            ORD_GT:  f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b0};
            default: f = '{n: 1'b0, z: 1'b0, c: 1'b1, v: 1'b1};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cmp_decode.sv
module cmp_decode
    import cmp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output decoded_t           dec
);
    logic [6:0] opf;

    always_comb begin
        opf       = {instr[11:8], instr[7:5]};
        dec.src_a = instr[19:16];
        dec.src_b = instr[3:0];
        dec.dest  = instr[15:12];
        dec.kind  = OPK_NONE;
        if (frame_ok(instr)) begin
            if (opf == OPF_DBL)      dec.kind = OPK_DBL;
            else if (opf == OPF_INT) dec.kind = OPK_INT;
        end
    end
endmodule

// File: rtl/cmp_int_core.sv
module cmp_int_core
    import cmp_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] a,
    input  logic [INT_W-1:0] b,
    output nzcv_t            flags
);
    logic [INT_W:0] diff;

    always_comb begin
        diff    = {1'b0, a} - {1'b0, b};
        flags.n = diff[INT_W-1];
        flags.z = (a == b);
        flags.c = !diff[INT_W];
        flags.v = (a[INT_W-1] != b[INT_W-1]) && (diff[INT_W-1] != a[INT_W-1]);
    end
endmodule

// File: rtl/cmp_dbl_core.sv
module cmp_dbl_core
    import cmp_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output nzcv_t                flags
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic [MAG_W-1:0] mag_a, mag_b;
    logic             sgn_a, sgn_b, nan_a, nan_b;
    order_e           ord;

    always_comb begin
        sgn_a = a[MAG_W];
        sgn_b = b[MAG_W];
        mag_a = a[MAG_W-1:0];
        mag_b = b[MAG_W-1:0];
        nan_a = (&mag_a[MAG_W-1:MAN_W]) && (|mag_a[MAN_W-1:0]);
        nan_b = (&mag_b[MAG_W-1:MAN_W]) && (|mag_b[MAN_W-1:0]);
        if (nan_a || nan_b)
            ord = ORD_UN;
        else if ((mag_a == '0 && mag_b == '0) || a == b)
            ord = ORD_EQ;
        else if (sgn_a != sgn_b)
            ord = sgn_a ? ORD_LT : ORD_GT;
        else if (!sgn_a)
            ord = (mag_a < mag_b) ? ORD_LT : ORD_GT;
        else
            ord = (mag_a > mag_b) ? ORD_LT : ORD_GT;
        flags = order_flags(ord);
    end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int INT_W  = 32,
    parameter int EXP_W  = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr_word,
    output logic [REG_AW-1:0]   rd_addr_a,
    input  logic [DATA_W-1:0]   rd_data_a,
    output logic [REG_AW-1:0]   rd_addr_b,
    input  logic [DATA_W-1:0]   rd_data_b,
    output logic                reg_we,
    output logic [REG_AW-1:0]   reg_waddr,
    output logic [RES_W-1:0]    reg_wdata,
    output logic                flag_we,
    output logic [FLAG_W-1:0]   flag_nzcv,
    output logic                undef_instr
);
    localparam int MAN_W = DATA_W - EXP_W - 1;

    decoded_t dec;
    nzcv_t    int_flags, dbl_flags, sel_flags;

    cmp_decode u_dec (.instr(instr_word), .dec(dec));

    cmp_int_core #(.INT_W(INT_W)) u_int (
        .a(rd_data_a[INT_W-1:0]), .b(rd_data_b[INT_W-1:0]), .flags(int_flags));

    cmp_dbl_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dbl (
        .a(rd_data_a), .b(rd_data_b), .flags(dbl_flags));

    assign rd_addr_a = dec.src_a;
    assign rd_addr_b = dec.src_b;
    assign sel_flags = (dec.kind == OPK_INT) ? int_flags : dbl_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we      <= 1'b0;
            flag_we     <= 1'b0;
            undef_instr <= 1'b0;
            reg_waddr   <= '0;
            reg_wdata   <= '0;
            flag_nzcv   <= '0;
        end else begin
            reg_we      <= 1'b0;
            flag_we     <= 1'b0;
            undef_instr <= 1'b0;
            if (instr_valid) begin
                if (dec.kind == OPK_NONE) begin
                    undef_instr <= 1'b1;
                end else if (dec.dest == FLAG_DEST) begin
                    flag_we   <= 1'b1;
                    flag_nzcv <= sel_flags;
                end else begin
                    reg_we    <= 1'b1;
                    reg_waddr <= dec.dest;
                    reg_wdata <= {sel_flags, {(RES_W-FLAG_W){1'b0}}};
                end
            end
        end
    end

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && flag_we));

    assert_outcome_after_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_we || flag_we || undef_instr) |-> $past(instr_valid));

    assert_valid_gets_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> (reg_we || flag_we || undef_instr));

    assert_undef_silent_R1: assert property (@(posedge clk) disable iff (rst)
        undef_instr |-> (!reg_we && !flag_we));

    assert_no_dest15_write_R5: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_waddr != FLAG_DEST));

    assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (reg_wdata[RES_W-FLAG_W-1:0] == '0));
endmodule

// File: tb/cmp_flag_unit_bench.sv
module cmp_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [3:0]  rd_addr_a, rd_addr_b;
    logic [63:0] rd_data_a, rd_data_b;
    logic        reg_we, flag_we, undef_instr;
    logic [3:0]  reg_waddr, flag_nzcv;
    logic [31:0] reg_wdata;

    logic [63:0] regs [16];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_P2   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_N1   = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_N2   = 64'hC000_0000_0000_0000;
    localparam logic [63:0] D_PZ   = 64'h0;
    localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_NAN  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_INF  = 64'h7FF0_0000_0000_0000;

    always #4 clk = ~clk;

    assign rd_data_a = regs[rd_addr_a];
    assign rd_data_b = regs[rd_addr_b];

    cmp_flag_unit u_cmp_flag_unit (.*);

    task automatic chk(input string tag, input logic ok,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cond, input bit dbl,
                                       input logic [3:0] a, input logic [3:0] d,
                                       input logic [3:0] b);
        return {cond, 4'b1110, 2'b00, 1'b0, 1'b1, a, d,
                dbl ? 4'b0100 : 4'b0101, dbl ? 3'b101 : 3'b100, 1'b1, b};
    endfunction

    // present one word, check read addresses, then the registered outcome
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_word  = w;
        instr_valid = 1'b1;
        #1;
        chk("R2 rd_addr_a", rd_addr_a == w[19:16], {28'b0, rd_addr_a}, {28'b0, w[19:16]});
        chk("R2 rd_addr_b", rd_addr_b == w[3:0], {28'b0, rd_addr_b}, {28'b0, w[3:0]});
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic expect_result(input string tag, input logic [3:0] d,
                                 input logic [3:0] nzcv);
        if (d == 4'd15) begin
            chk({tag, " flag_we"}, flag_we && !reg_we && !undef_instr,
                {29'b0, reg_we, flag_we, undef_instr}, 32'h2);
            chk({tag, " flags"}, flag_nzcv == nzcv, {28'b0, flag_nzcv}, {28'b0, nzcv});
        end else begin
            chk({tag, " reg_we"}, reg_we && !flag_we && !undef_instr,
                {29'b0, reg_we, flag_we, undef_instr}, 32'h4);
            chk({tag, " waddr"}, reg_waddr == d, {28'b0, reg_waddr}, {28'b0, d});
            chk({tag, " wdata R4"}, reg_wdata == {nzcv, 28'b0}, reg_wdata, {nzcv, 28'b0});
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        chk({tag, " idle R10"}, !reg_we && !flag_we && !undef_instr,
            {29'b0, reg_we, flag_we, undef_instr}, 32'h0);
    endtask

    task automatic run_cmp(input string tag, input bit dbl, input logic [63:0] va,
                           input logic [63:0] vb, input logic [3:0] d,
                           input logic [3:0] nzcv);
        regs[3] = va;
        regs[9] = vb;
        issue(mk(4'hE, dbl, 4'd3, d, 4'd9));
        expect_result(tag, d, nzcv);
    endtask

    task automatic test_reset();
        chk("R10 reset strobes", !reg_we && !flag_we && !undef_instr,
            {29'b0, reg_we, flag_we, undef_instr}, 32'h0);
    endtask

    task automatic test_int();
        run_cmp("R6 gt", 0, 64'd5, 64'd3, 4'd2, 4'b0010);
        expect_idle("R6 gt");
        run_cmp("R6 lt", 0, 64'd3, 64'd5, 4'd7, 4'b1000);
        run_cmp("R6 eq", 0, 64'd7, 64'd7, 4'd1, 4'b0110);
        run_cmp("R6 ovf pos", 0, 64'h7FFF_FFFF, 64'hFFFF_FFFF, 4'd4, 4'b1001);
        run_cmp("R6 ovf neg", 0, 64'h8000_0000, 64'd1, 4'd5, 4'b0011);
        run_cmp("R12 upper ignored", 0, 64'hAAAA_0000_0000_0011,
                64'h1234_5678_0000_0011, 4'd6, 4'b0110);
    endtask

    task automatic test_dbl();
        run_cmp("R7 lt", 1, D_P1, D_P2, 4'd2, 4'b1000);
        run_cmp("R7 gt", 1, D_P2, D_P1, 4'd2, 4'b0010);
        run_cmp("R7 neg lt", 1, D_N2, D_N1, 4'd3, 4'b1000);
        run_cmp("R7 mixed lt", 1, D_N1, D_P1, 4'd8, 4'b1000);
        run_cmp("R7 eq", 1, D_P1, D_P1, 4'd0, 4'b0110);
        run_cmp("R7 inf gt", 1, D_INF, D_P2, 4'd0, 4'b0010);
        run_cmp("R9 pz nz", 1, D_PZ, D_NZ, 4'd11, 4'b0110);
        run_cmp("R9 nz pz", 1, D_NZ, D_PZ, 4'd11, 4'b0110);
        run_cmp("R8 nan a", 1, D_NAN, D_P1, 4'd12, 4'b0011);
        run_cmp("R8 nan b", 1, D_P1, D_NAN, 4'd12, 4'b0011);
    endtask

    task automatic test_flag_dest();
        run_cmp("R5 int dest15", 0, 64'd3, 64'd5, 4'd15, 4'b1000);
        expect_idle("R5");
        run_cmp("R5 dbl dest15", 1, D_NAN, D_P1, 4'd15, 4'b0011);
    endtask

    task automatic test_cond();
        regs[3] = 64'd5;
        regs[9] = 64'd3;
        issue(mk(4'h0, 0, 4'd3, 4'd10, 4'd9));
        expect_result("R11 cond 0", 4'd10, 4'b0010);
        issue(mk(4'hF, 0, 4'd3, 4'd10, 4'd9));
        expect_result("R11 cond F", 4'd10, 4'b0010);
    endtask

    task automatic expect_undef(input string tag, input logic [31:0] w);
        issue(w);
        chk(tag, undef_instr && !reg_we && !flag_we,
            {29'b0, reg_we, flag_we, undef_instr}, 32'h1);
    endtask

    task automatic test_undef();
        logic [31:0] good;
        good = mk(4'hE, 1, 4'd3, 4'd2, 4'd9);
        expect_undef("R1 bit4 clear", good & ~32'h10);
        expect_undef("R1 bit20 clear", good & ~32'h0010_0000);
        expect_undef("R1 bit21 set", good | 32'h0020_0000);
        expect_undef("R1 bits27:24", good ^ 32'h0100_0000);
        expect_undef("R3 bad op 0110", {good[31:12], 4'b0110, good[7:0]});
        expect_undef("R3 dbl op wrong sub", {good[31:12], 4'b0100, 3'b100, good[4:0]});
        expect_undef("R3 int op wrong sub", {good[31:12], 4'b0101, 3'b101, good[4:0]});
        expect_idle("R1");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_int();
        test_dbl();
        test_flag_dest();
        test_cond();
        test_undef();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule